// File: doc/BRIEF.md
# Serial Command Port with Transmit and Receive Byte Queues

This block is the serial front end of a radio-style peripheral. A host talks to it over a four-wire SPI link in mode 0, most significant bit first. Each transaction is framed by an active-low chip select, and the first byte inside the frame is an opcode. One opcode streams every following byte into a transmit queue. Another opcode streams bytes out of a receive queue for as long as the host keeps clocking. The local logic fills the receive queue and empties the transmit queue through a simple push/pop interface with full and empty flags.

Writing into a full transmit queue, or reading from an empty receive queue, sets a sticky error flag. When the host has enabled it, that flag pulls an active-low interrupt line low. The host clears the flag with a status opcode, which returns a status byte and then releases the line. A configuration opcode sets the interrupt enable. The serial clock, select and data input are synchronised to the system clock, which must run at least eight times faster than the serial clock.

Top module: `spi_fifo_port`

## Requirements
- R1: After reset irqN is high, miso is low, txEmpty is high and rxFull is low.
- R2: Opcode 0x66 pushes every later byte of the same transaction into the transmit queue, and the local side pops them from txData in the order they were sent.
- R3: A byte written under 0x66 while the transmit queue already holds 64 bytes is discarded and sets the error flag.
- R4: Opcode 0x77 shifts receive queue bytes out on miso, MSB first and one per byte time, in arrival order. The host sets the count by how long it clocks, and bytes it does not clock out stay queued.
- R5: A read byte time under 0x77 with the receive queue empty shifts out 0x00 and sets the error flag.
- R6: Opcode 0x20 shifts out one status byte with bit 0 = error flag, bit 1 = interrupt enable and bits 7:2 = 0. The flag's value is taken before clearing, and the flag is cleared once that byte starts shifting.
- R7: The error flag stays set across other transactions until a status read clears it.
- R8: Opcode 0x21 followed by one data byte loads interrupt enable from bit 0 of that byte. irqN is low exactly when the error flag and the enable are both set.
- R9: Any other opcode makes miso return 0xFF for every later byte of that transaction, and those bytes change no queue or flag.
- R10: rxPush while rxFull is high and txPop while txEmpty is high are ignored. Each queue holds 64 bytes.
- R11: Raising chip select ends the transaction and drops any partial byte, so the next transaction starts with a fresh opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from host, idle low |
| csN | input | 1 | Active-low chip select framing a transaction |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host, changes after falling sclk |
| irqN | output | 1 | Active-low interrupt, low when error flag and enable are set |
| txPop | input | 1 | Local pop of the transmit queue head |
| txData | output | 8 | Transmit queue head byte |
| txEmpty | output | 1 | Transmit queue is empty |
| rxPush | input | 1 | Local push of rxData into the receive queue |
| rxData | input | 8 | Byte to push into the receive queue |
| rxFull | output | 1 | Receive queue is full |

## Verification
Random write bursts of random length and content, drained locally, show whether the transmit path keeps order and loses or duplicates nothing. Random receive fills read back in random-length pieces across several transactions show whether unclocked bytes survive the end of a frame, including the extra falling edge at the end. Directed cases fill each queue to exactly 64 and one beyond, read an empty queue, send an unknown opcode and abort a frame mid-byte. This separates the discard, underflow, ignore and resynchronise paths. Status reads with the enable on and off tell sticky setting, clearing and interrupt gating apart.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

  localparam logic [7:0] OP_TX_WRITE = 8'h66;
  localparam logic [7:0] OP_RX_READ  = 8'h77;
  localparam logic [7:0] OP_STATUS   = 8'h20;
  localparam logic [7:0] OP_CONFIG   = 8'h21;
  localparam logic [7:0] FILL_BAD    = 8'hFF;
  localparam logic [7:0] FILL_IDLE   = 8'h00;

  // strobes from control into the datapath
  typedef struct packed {
    logic       pushTx;
    logic       popRx;
    logic       loadOut;
    logic [7:0] outByte;
  } ctrl_strobe_t;

  // events from the serial datapath up to control
  typedef struct packed {
    logic       active;
    logic       byteDone;
    logic [7:0] inByte;
    logic       loadSlot;
    logic       commitSlot;
  } link_event_t;

  typedef enum logic [2:0] {
    ST_CMD, ST_WRITE, ST_READ, ST_STATUS, ST_CONFIG, ST_SKIP, ST_BAD
  } cmd_state_t;

  typedef enum logic [1:0] {
    PEND_NONE, PEND_POP, PEND_EMPTY, PEND_STATUS
  } pend_kind_t;

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [AW:0]      count;
  logic             doPush, doPop;

  assign full   = (count == (AW+1)'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // a push into a full queue must not change the fill level
  assert_full_push_dropped_R10: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop) |=> full);
  // a pop from an empty queue leaves it empty
  assert_empty_pop_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (pop && empty && !push) |=> empty);
endmodule

// File: rtl/spi_datapath.sv
module spi_datapath
  import spi_fifo_pkg::*;
#(
  parameter int FIFO_DEPTH  = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclk,
  input  logic         csN,
  input  logic         mosi,
  output logic         miso,
  input  ctrl_strobe_t ctrl,
  output link_event_t  ev,
  input  logic         txPop,
  output logic [7:0]   txData,
  output logic         txEmpty,
  input  logic         rxPush,
  input  logic [7:0]   rxData,
  output logic         rxFull,
  output logic [7:0]   rxHead,
  output logic         rxEmpty,
  output logic         txFull
);
  logic [SYNC_STAGES:0]   sclkPipe;
  logic [SYNC_STAGES-1:0] csPipe, mosiPipe;
  logic sclkRise, sclkFall, active, mosiNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe <= '0;
      csPipe   <= '1;
      mosiPipe <= '0;
    end else begin
      sclkPipe <= {sclkPipe[SYNC_STAGES-1:0], sclk};
      csPipe   <= {csPipe[SYNC_STAGES-2:0], csN};
      mosiPipe <= {mosiPipe[SYNC_STAGES-2:0], mosi};
    end
  end

  assign sclkRise = sclkPipe[SYNC_STAGES-1] && !sclkPipe[SYNC_STAGES];
  assign sclkFall = !sclkPipe[SYNC_STAGES-1] && sclkPipe[SYNC_STAGES];
  assign active   = !csPipe[SYNC_STAGES-1];
  assign mosiNow  = mosiPipe[SYNC_STAGES-1];

  // receive shifter and bit counter
  logic [2:0] bitCnt;
  logic [6:0] shiftIn;
  logic       byteSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftIn  <= '0;
      byteSeen <= 1'b0;
    end else if (!active) begin
      bitCnt   <= '0;
      byteSeen <= 1'b0;
    end else if (sclkRise) begin
      shiftIn <= {shiftIn[5:0], mosiNow};
      bitCnt  <= bitCnt + 1'b1;
      if (bitCnt == 3'd7) byteSeen <= 1'b1;
    end
  end

  always_comb begin
    ev.active     = active;
    ev.byteDone   = active && sclkRise && (bitCnt == 3'd7);
    ev.inByte     = {shiftIn, mosiNow};
    ev.loadSlot   = active && sclkFall && (bitCnt == 3'd0) && byteSeen;
    ev.commitSlot = active && sclkRise && (bitCnt == 3'd0) && byteSeen;
  end

  // transmit shifter, advances on falling sclk
  logic       misoReg;
  logic [6:0] outShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      misoReg  <= 1'b0;
      outShift <= '0;
    end else if (!active) begin
      misoReg  <= 1'b0;
      outShift <= '0;
    end else if (ctrl.loadOut) begin
      misoReg  <= ctrl.outByte[7];
      outShift <= ctrl.outByte[6:0];
    end else if (sclkFall) begin
      misoReg  <= outShift[6];
      outShift <= {outShift[5:0], 1'b0};
    end
  end

  assign miso = misoReg;

  byte_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) txQueue (
    .clk(clk), .rstN(rstN),
    .push(ctrl.pushTx), .pushData(ev.inByte), .pop(txPop),
    .head(txData), .full(txFull), .empty(txEmpty)
  );

  byte_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) rxQueue (
    .clk(clk), .rstN(rstN),
    .push(rxPush), .pushData(rxData), .pop(ctrl.popRx),
    .head(rxHead), .full(rxFull), .empty(rxEmpty)
  );

  // deselect clears the partial byte and quiets the output
  assert_deselect_resets_R11: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> (bitCnt == 3'd0 && !miso));
  // a load and a shift never coincide with a rising edge
  assert_load_on_fall_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadOut |-> sclkFall);
endmodule

// File: rtl/spi_control.sv
module spi_control
  import spi_fifo_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  link_event_t  ev,
  input  logic [7:0]   rxHead,
  input  logic         rxEmpty,
  input  logic         txFull,
  output ctrl_strobe_t ctrl,
  output logic         irqN
);
  cmd_state_t state;
  pend_kind_t pend;
  logic errFlag, irqEn;
  logic overflowHit, underflowHit, statusClear;

  assign overflowHit  = ev.byteDone && (state == ST_WRITE) && txFull;
  assign underflowHit = ev.commitSlot && (pend == PEND_EMPTY);
  assign statusClear  = ev.commitSlot && (pend == PEND_STATUS);

  always_comb begin
    ctrl = '0;
    ctrl.pushTx = ev.byteDone && (state == ST_WRITE) && !txFull;
    ctrl.popRx  = ev.commitSlot && (pend == PEND_POP);
    if (ev.loadSlot) begin
      ctrl.loadOut = 1'b1;
      unique case (state)
        ST_READ:   ctrl.outByte = rxEmpty ? FILL_IDLE : rxHead;
        ST_STATUS: ctrl.outByte = {6'b0, irqEn, errFlag};
        ST_BAD:    ctrl.outByte = FILL_BAD;
        default:   ctrl.outByte = FILL_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag <= 1'b0;
    end else if (overflowHit || underflowHit) begin
      errFlag <= 1'b1;
    end else if (statusClear) begin
      errFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_CMD;
      pend  <= PEND_NONE;
      irqEn <= 1'b0;
    end else if (!ev.active) begin
      state <= ST_CMD;
      pend  <= PEND_NONE;
    end else begin
      if (ev.byteDone) begin
        unique case (state)
          ST_CMD: begin
            unique case (ev.inByte)
              OP_TX_WRITE: state <= ST_WRITE;
              OP_RX_READ:  state <= ST_READ;
              OP_STATUS:   state <= ST_STATUS;
              OP_CONFIG:   state <= ST_CONFIG;
              default:     state <= ST_BAD;
            endcase
          end
          ST_CONFIG: begin
            irqEn <= ev.inByte[0];
            state <= ST_SKIP;
          end
          default: state <= state;
        endcase
      end
      if (ev.loadSlot) begin
        unique case (state)
          ST_READ:   pend <= rxEmpty ? PEND_EMPTY : PEND_POP;
          ST_STATUS: pend <= PEND_STATUS;
          default:   pend <= PEND_NONE;
        endcase
      end
      if (ev.commitSlot) begin
        pend <= PEND_NONE;
        if (pend == PEND_STATUS) state <= ST_SKIP;
      end
    end
  end

  assign irqN = !(errFlag && irqEn);

  assert_overflow_sets_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
    overflowHit |=> errFlag);
  assert_underflow_sets_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    underflowHit |=> errFlag);
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !statusClear) |=> errFlag);
  assert_status_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (statusClear && !overflowHit && !underflowHit) |=> !errFlag);
  assert_no_pop_when_empty_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.popRx, underflowHit, statusClear}));
endmodule

// File: rtl/spi_fifo_port.sv
module spi_fifo_port
  import spi_fifo_pkg::*;
#(
  parameter int FIFO_DEPTH  = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclk,
  input  logic       csN,
  input  logic       mosi,
  output logic       miso,
  output logic       irqN,
  input  logic       txPop,
  output logic [7:0] txData,
  output logic       txEmpty,
  input  logic       rxPush,
  input  logic [7:0] rxData,
  output logic       rxFull
);
  ctrl_strobe_t ctrl;
  link_event_t  ev;
  logic [7:0]   rxHead;
  logic         rxEmpty, txFull;

  spi_datapath #(.FIFO_DEPTH(FIFO_DEPTH), .SYNC_STAGES(SYNC_STAGES)) datapath (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso),
    .ctrl(ctrl), .ev(ev),
    .txPop(txPop), .txData(txData), .txEmpty(txEmpty),
    .rxPush(rxPush), .rxData(rxData), .rxFull(rxFull),
    .rxHead(rxHead), .rxEmpty(rxEmpty), .txFull(txFull)
  );

  spi_control control (
    .clk(clk), .rstN(rstN), .ev(ev), .rxHead(rxHead), .rxEmpty(rxEmpty),
    .txFull(txFull), .ctrl(ctrl), .irqN(irqN)
  );
endmodule

// File: tb/tb_spi_fifo_port.sv
module tb_spi_fifo_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int DEPTH      = 64;

  logic clk = 1'b0, rstN = 1'b0;
  logic sclk = 1'b0, csN = 1'b1, mosi = 1'b0;
  logic miso, irqN, txPop = 1'b0, txEmpty, rxPush = 1'b0, rxFull;
  logic [7:0] txData, rxData = 8'h00;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] txModel[$];
  logic [7:0] rxModel[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_fifo_port dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso),
    .irqN(irqN), .txPop(txPop), .txData(txData), .txEmpty(txEmpty),
    .rxPush(rxPush), .rxData(rxData), .rxFull(rxFull)
  );

  function automatic logic [7:0] statusExp(input logic err, input logic en);
    return {6'b0, en, err};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic csLow();
    @(negedge clk); csN = 1'b0; waitClk(HALF);
  endtask

  task automatic csHigh();
    waitClk(HALF); csN = 1'b1; waitClk(HALF);
  endtask

  task automatic spiByte(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      mosi = b[i];
      waitClk(HALF);
      r[i] = miso;
      sclk = 1'b1;
      waitClk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic localPush(input logic [7:0] d);
    @(negedge clk); rxPush = 1'b1; rxData = d;
    @(negedge clk); rxPush = 1'b0;
  endtask

  task automatic drainTx(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(req, txData, txModel.pop_front());
      txPop = 1'b1;
      @(negedge clk); txPop = 1'b0;
    end
  endtask

  task automatic doStatus(input logic [7:0] exp, input string req);
    logic [7:0] r;
    csLow(); spiByte(8'h20, r); spiByte(8'h00, r); csHigh();
    check(req, r, exp);
  endtask

  task automatic readRx(input int n, input string req);
    logic [7:0] r;
    csLow(); spiByte(8'h77, r);
    for (int i = 0; i < n; i++) begin
      spiByte(8'h00, r);
      check(req, r, (rxModel.size() > 0) ? rxModel.pop_front() : 8'h00);
    end
    csHigh();
  endtask

  initial begin
    int wd = 0;
    while (!finished && wd < 200000) begin @(posedge clk); wd++; end
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, b;
    logic errM, enM;
    int n;
    void'($urandom(32'd20240611));
    errM = 0; enM = 0;
    waitClk(5); rstN = 1'b1; waitClk(3);

    // R1 reset state
    check("R1 irqN", irqN, 1); check("R1 miso", miso, 0);
    check("R1 txEmpty", txEmpty, 1); check("R1 rxFull", rxFull, 0);

    // R8 enable interrupt, no error yet
    csLow(); spiByte(8'h21, r); spiByte(8'h01, r); csHigh(); enM = 1;
    check("R8 irqN idle with enable", irqN, 1);

    // R2 random write bursts
    for (int round = 0; round < 4; round++) begin
      n = $urandom_range(1, 20);
      csLow(); spiByte(8'h66, r);
      for (int i = 0; i < n; i++) begin
        b = 8'($urandom); txModel.push_back(b); spiByte(b, r);
      end
      csHigh();
      drainTx("R2 tx order", n);
      check("R2 tx drained", txEmpty, 1);
    end

    // R3 overflow at 65th byte
    csLow(); spiByte(8'h66, r);
    for (int i = 0; i < DEPTH + 1; i++) begin
      if (i < DEPTH) txModel.push_back(8'(i + 3));
      spiByte(8'(i + 3), r);
    end
    csHigh(); errM = 1;
    check("R8 irqN on error", irqN, 0);
    drainTx("R3 tx kept 64", DEPTH);
    check("R3 extra byte discarded", txEmpty, 1);

    // R7 flag survives another transaction
    csLow(); spiByte(8'h66, r); spiByte(8'h5A, r); csHigh();
    txModel.push_back(8'h5A); drainTx("R7 unrelated write", 1);
    check("R7 flag sticky", irqN, 0);

    // R6 status returns then clears
    doStatus(statusExp(errM, enM), "R6 status with error"); errM = 0;
    check("R6 irq released", irqN, 1);
    doStatus(statusExp(errM, enM), "R6 status after clear");

    // R4 random receive fills, partial reads
    for (int round = 0; round < 3; round++) begin
      n = $urandom_range(1, 20);
      for (int i = 0; i < n; i++) begin
        b = 8'($urandom); rxModel.push_back(b); localPush(b);
      end
      readRx($urandom_range(1, n), "R4 rx order");
    end
    readRx(rxModel.size(), "R4 rx leftovers");
    check("R4 no false error", irqN, 1);

    // R5 underflow
    readRx(2, "R5 underflow zero"); errM = 1;
    check("R5 irq on underflow", irqN, 0);
    doStatus(statusExp(errM, enM), "R5 status"); errM = 0;

    // R8 disabled interrupt gating
    csLow(); spiByte(8'h21, r); spiByte(8'h00, r); csHigh(); enM = 0;
    readRx(1, "R8 underflow masked"); errM = 1;
    check("R8 irq masked", irqN, 1);
    doStatus(statusExp(errM, enM), "R8 status masked"); errM = 0;

    // R9 unknown opcode
    csLow(); spiByte(8'h5C, r); spiByte(8'h12, r);
    check("R9 fill byte", r, 8'hFF); spiByte(8'h34, r);
    check("R9 fill byte 2", r, 8'hFF); csHigh();
    check("R9 tx untouched", txEmpty, 1);
    doStatus(statusExp(errM, enM), "R9 no flag");

    // R10 full receive queue ignores push; empty tx ignores pop
    for (int i = 0; i < DEPTH; i++) begin
      b = 8'($urandom); rxModel.push_back(b); localPush(b);
    end
    check("R10 rxFull", rxFull, 1);
    localPush(8'hAA);
    readRx(DEPTH + 1, "R10 extra push dropped"); errM = 1;
    doStatus(statusExp(errM, enM), "R10 underflow after 64"); errM = 0;
    @(negedge clk); txPop = 1'b1; @(negedge clk); txPop = 1'b0;
    check("R10 tx still empty", txEmpty, 1);
    csLow(); spiByte(8'h66, r); spiByte(8'hC3, r); csHigh();
    txModel.push_back(8'hC3); drainTx("R10 pointers intact", 1);

    // R11 aborted partial byte
    csLow();
    for (int i = 0; i < 3; i++) begin
      mosi = 1'b1; waitClk(HALF); sclk = 1'b1; waitClk(HALF); sclk = 1'b0;
    end
    csHigh();
    csLow(); spiByte(8'h66, r); spiByte(8'h3C, r); csHigh();
    check("R11 fresh opcode", txEmpty, 0);
    txModel.push_back(8'h3C); drainTx("R11 data", 1);
    check("R11 no error", irqN, 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule